// File: doc/BRIEF.md
# Synchronous Slave Serial Port

This block is a half-duplex serial port that runs as a slave. An external master supplies the bit clock on a clock pin and moves data over one bidirectional data pin. All shifting is clocked by that external clock alone, so the port keeps receiving and transmitting while the host clock is gated off. When a word finishes, a request output can wake a sleeping host.

On the receive side, the port shifts in a word and parks it in a holding register, then raises a receive flag. The host reads the word, which clears the flag. A word that completes while the holding register is still occupied is dropped and sets an overrun flag. On the transmit side, the host writes into a holding register. When the shift register is empty, it takes that word, so two words can be queued at once. As the last bit of a word goes out, the next queued word follows with no gap, and the transmit flag reports that the holding register is free again.

Flag events travel into the host domain through toggle handshakes and multi-flop synchronizers. The wake output is formed without any host-clock register, so it still rises while the host clock is stopped.

Top module: `sync_slave_port`

## Requirements
- R1: While the host reset is held, and once it is released, the receive and overrun flags are clear, the transmit flag is set (transmit holding register empty), the data pin is not driven, and both bit counters restart from zero, so a partly shifted word is discarded.
- R2: When `en_i`=1 and `mode_tx_i`=0, the port samples `data_i` on each falling edge of `sclk_i`. Eight samples form one word, and the first sample becomes bit 0. When `en_i`=0, or when `mode_tx_i`=1, falling edges produce no received word.
- R3: When the eighth bit arrives, the word moves into the receive holding register, `rx_flag_o` goes to 1, and `rdata_o` stays unchanged for as long as the flag stays set.
- R4: A host read (`rd_i`=1 while `rx_flag_o`=1) clears `rx_flag_o` and `ovr_flag_o` on the next host clock. No other event clears `rx_flag_o`.
- R5: If a word completes while the receive holding register is still full, `ovr_flag_o` goes to 1, the new word is discarded, and `rdata_o` keeps the earlier word.
- R6: A host write (`wr_i`=1 while `tx_flag_o`=1) stores `wdata_i` and clears `tx_flag_o` on the next host clock. A write while `tx_flag_o`=0 is ignored, and its data is never transmitted.
- R7: When the transmit shift register is empty and a word is waiting in the holding register, the third rising `sclk_i` edge after the write loads that word. Bit 0 then appears on `data_o` at once. Each later rising edge presents the next bit, and no change happens without `sclk_i` edges.
- R8: On the rising edge that follows the eighth bit, a waiting holding-register word loads immediately, so `data_oe_o` stays 1, and `tx_flag_o` goes to 1. With no waiting word, the shift register empties.
- R9: `data_oe_o` is 1 only when `en_i`=1, `mode_tx_i`=1 and a word is loaded in the transmit shift register.
- R10: `wake_o` = `pie_i` AND ((`rx_ie_i` AND receive word pending) OR (`tx_ie_i` AND transmit holding empty)). It follows external-clock events while the host clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_i | input | 1 | Host synchronous reset, active high |
| en_i | input | 1 | Port enable |
| mode_tx_i | input | 1 | 1 = transmit, 0 = receive |
| sclk_i | input | 1 | External slave bit clock |
| data_i | input | 1 | Data pin input |
| data_o | output | 1 | Data pin output value |
| data_oe_o | output | 1 | Data pin output enable |
| wr_i | input | 1 | Write transmit holding register |
| wdata_i | input | WORD_W | Transmit word |
| rd_i | input | 1 | Read (acknowledge) receive holding register |
| rdata_o | output | WORD_W | Received word |
| rx_flag_o | output | 1 | Received word pending |
| tx_flag_o | output | 1 | Transmit holding register free |
| ovr_flag_o | output | 1 | Receive overrun |
| rx_ie_i | input | 1 | Receive wake enable |
| tx_ie_i | input | 1 | Transmit wake enable |
| pie_i | input | 1 | Peripheral request enable |
| wake_o | output | 1 | Wake / interrupt request |

## Verification
The bench gates the host clock off and then clocks complete words in and out. A wake path that depends on host registers would stay low in that case. It sends a second word before the first is read, to catch a design that overwrites the holding register instead of flagging the overrun. It queues two transmit words and counts the exact load edge. A design that adds a gap between back-to-back words would drop the pin enable, and one that forwards an ignored write would send the wrong byte. Reset arrives in the middle of a word, so a stale bit counter would misalign the next received byte.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
   localparam int FLAG_N = 3;
   localparam int RX_IDX = 0;
   localparam int OVR_IDX = 1;
   localparam int TAKE_IDX = 2;

   typedef struct packed {
      logic ovr;
      logic tx;
      logic rx;
   } ssp_flags_t;
endpackage

// File: rtl/ssp_sync.sv
`timescale 1ns/1ps
module ssp_sync #(
   parameter int STAGES   = 2,
   parameter bit NEG_EDGE = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (NEG_EDGE) begin : g_neg
         always_ff @(negedge clk_i or posedge rst_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end else begin : g_pos
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ssp_rx.sv
`timescale 1ns/1ps
module ssp_rx #(
   parameter int WORD_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              sclk_i,
   input  logic              rst_i,
   input  logic              active_i,
   input  logic              data_i,
   input  logic              ack_tog_i,
   output logic [WORD_W-1:0] hold_o,
   output logic              load_tog_o,
   output logic              ovr_tog_o
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sr_q;
   logic [WORD_W-1:0] sr_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              full;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sr_nxt = {data_i, sr_q[WORD_W-1:1]};
      end else begin : g_msb
         assign sr_nxt = {sr_q[WORD_W-2:0], data_i};
      end
   endgenerate

   assign full = load_tog_o ^ ack_tog_i;

   always_ff @(negedge sclk_i or posedge rst_i) begin
      if (rst_i) begin
         sr_q       <= '0;
         cnt_q      <= '0;
         hold_o     <= '0;
         load_tog_o <= 1'b0;
         ovr_tog_o  <= 1'b0;
      end else if (!active_i) begin
         cnt_q <= '0;
      end else begin
         sr_q <= sr_nxt;
         if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (full) begin
               ovr_tog_o <= ~ovr_tog_o;
            end else begin
               hold_o     <= sr_nxt;
               load_tog_o <= ~load_tog_o;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ssp_tx.sv
`timescale 1ns/1ps
module ssp_tx #(
   parameter int WORD_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              sclk_i,
   input  logic              rst_i,
   input  logic              active_i,
   input  logic [WORD_W-1:0] hold_i,
   input  logic              wr_tog_i,
   output logic              take_tog_o,
   output logic              data_o,
   output logic              loaded_o
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sr_q;
   logic [WORD_W-1:0] sr_shift;
   logic [CNT_W-1:0]  cnt_q;
   logic              pend;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sr_shift = {1'b0, sr_q[WORD_W-1:1]};
         assign data_o   = sr_q[0];
      end else begin : g_msb
         assign sr_shift = {sr_q[WORD_W-2:0], 1'b0};
         assign data_o   = sr_q[WORD_W-1];
      end
   endgenerate

   assign pend = wr_tog_i ^ take_tog_o;

   always_ff @(posedge sclk_i or posedge rst_i) begin
      if (rst_i) begin
         sr_q       <= '0;
         cnt_q      <= '0;
         loaded_o   <= 1'b0;
         take_tog_o <= 1'b0;
      end else if (!active_i) begin
         cnt_q    <= '0;
         loaded_o <= 1'b0;
      end else if (!loaded_o || cnt_q == LAST) begin
         cnt_q <= '0;
         if (pend) begin
            sr_q       <= hold_i;
            loaded_o   <= 1'b1;
            take_tog_o <= ~take_tog_o;
         end else begin
            loaded_o <= 1'b0;
         end
      end else begin
         sr_q  <= sr_shift;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ssp_host.sv
`timescale 1ns/1ps
module ssp_host
   import ssp_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              rst_x_i,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              rd_i,
   input  logic              load_tog_i,
   input  logic              ovr_tog_i,
   input  logic              take_tog_i,
   output logic [WORD_W-1:0] thold_o,
   output logic              wr_tog_o,
   output logic              ack_tog_o,
   output ssp_flags_t        flags_o
);
   logic [FLAG_N-1:0] raw_tog;
   logic [FLAG_N-1:0] syn_tog;
   logic              ovr_ack_q;

   assign raw_tog[RX_IDX]   = load_tog_i;
   assign raw_tog[OVR_IDX]  = ovr_tog_i;
   assign raw_tog[TAKE_IDX] = take_tog_i;

   for (genvar g = 0; g < FLAG_N; g++) begin : g_sync
      ssp_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) sync_i (
         .clk_i (clk_i),
         .rst_i (rst_x_i),
         .d_i   (raw_tog[g]),
         .q_o   (syn_tog[g])
      );
   end

   assign flags_o.rx  = syn_tog[RX_IDX] ^ ack_tog_o;
   assign flags_o.ovr = syn_tog[OVR_IDX] ^ ovr_ack_q;
   assign flags_o.tx  = ~(syn_tog[TAKE_IDX] ^ wr_tog_o);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         thold_o   <= '0;
         wr_tog_o  <= 1'b0;
         ack_tog_o <= 1'b0;
         ovr_ack_q <= 1'b0;
      end else begin
         if (rd_i && flags_o.rx) begin
            ack_tog_o <= ~ack_tog_o;
            ovr_ack_q <= syn_tog[OVR_IDX];
         end
         if (wr_i && flags_o.tx) begin
            thold_o  <= wdata_i;
            wr_tog_o <= ~wr_tog_o;
         end
      end
   end
endmodule

// File: rtl/sync_slave_port.sv
`timescale 1ns/1ps
module sync_slave_port
   import ssp_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic              mode_tx_i,
   input  logic              sclk_i,
   input  logic              data_i,
   output logic              data_o,
   output logic              data_oe_o,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic              rx_flag_o,
   output logic              tx_flag_o,
   output logic              ovr_flag_o,
   input  logic              rx_ie_i,
   input  logic              tx_ie_i,
   input  logic              pie_i,
   output logic              wake_o
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("sync_slave_port: WORD_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sync_slave_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rst_x_q;
   logic              rx_active;
   logic              tx_active;
   logic              load_tog, ovr_tog, take_tog;
   logic              wr_tog, ack_tog;
   logic              wr_tog_s, ack_tog_s;
   logic              tx_loaded;
   logic [WORD_W-1:0] thold;
   ssp_flags_t        flags;
   logic              rx_pend_raw, tx_free_raw;

   // registered copy of the host reset drives the external-clock domain
   always_ff @(posedge clk_i) rst_x_q <= rst_i;

   assign rx_active = en_i & ~mode_tx_i;
   assign tx_active = en_i & mode_tx_i;

   ssp_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) ack_sync_i (
      .clk_i (sclk_i), .rst_i (rst_x_q), .d_i (ack_tog), .q_o (ack_tog_s)
   );

   ssp_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) wr_sync_i (
      .clk_i (sclk_i), .rst_i (rst_x_q), .d_i (wr_tog), .q_o (wr_tog_s)
   );

   ssp_rx #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) rx_i (
      .sclk_i     (sclk_i),
      .rst_i      (rst_x_q),
      .active_i   (rx_active),
      .data_i     (data_i),
      .ack_tog_i  (ack_tog_s),
      .hold_o     (rdata_o),
      .load_tog_o (load_tog),
      .ovr_tog_o  (ovr_tog)
   );

   ssp_tx #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) tx_i (
      .sclk_i     (sclk_i),
      .rst_i      (rst_x_q),
      .active_i   (tx_active),
      .hold_i     (thold),
      .wr_tog_i   (wr_tog_s),
      .take_tog_o (take_tog),
      .data_o     (data_o),
      .loaded_o   (tx_loaded)
   );

   ssp_host #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) host_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rst_x_i    (rst_x_q),
      .wr_i       (wr_i),
      .wdata_i    (wdata_i),
      .rd_i       (rd_i),
      .load_tog_i (load_tog),
      .ovr_tog_i  (ovr_tog),
      .take_tog_i (take_tog),
      .thold_o    (thold),
      .wr_tog_o   (wr_tog),
      .ack_tog_o  (ack_tog),
      .flags_o    (flags)
   );

   assign data_oe_o  = tx_active & tx_loaded;
   assign rx_flag_o  = flags.rx;
   assign tx_flag_o  = flags.tx;
   assign ovr_flag_o = flags.ovr;

   // wake path uses the unsynchronised toggles: no host clock needed
   assign rx_pend_raw = load_tog ^ ack_tog;
   assign tx_free_raw = ~(take_tog ^ wr_tog);
   assign wake_o = pie_i & ((rx_ie_i & rx_pend_raw) | (tx_ie_i & tx_free_raw));
endmodule

// File: rtl/ssp_chk.sv
`timescale 1ns/1ps
module ssp_chk #(
   parameter int WORD_W = 8
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              en_i,
   input logic              rd_i,
   input logic              wr_i,
   input logic [WORD_W-1:0] rdata_o,
   input logic              rx_flag_o,
   input logic              tx_flag_o,
   input logic              data_oe_o,
   input logic              rx_ie_i,
   input logic              tx_ie_i,
   input logic              pie_i,
   input logic              wake_o
);
   // R4
   rd_clears_rx_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_i && rx_flag_o) |=> !rx_flag_o);

   // R4
   rx_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rx_flag_o && !rd_i) |=> rx_flag_o);

   // R3
   rdata_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rx_flag_o && !rd_i) |=> $stable(rdata_o));

   // R6
   wr_clears_tx_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_i && tx_flag_o) |=> !tx_flag_o);

   // R8
   tx_free_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (tx_flag_o && !wr_i) |=> tx_flag_o);

   // R9
   no_drive_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |-> !data_oe_o);

   // R10
   rx_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pie_i && rx_ie_i && rx_flag_o) |-> wake_o);

   // R10
   tx_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pie_i && tx_ie_i && tx_flag_o) |-> wake_o);
endmodule

bind sync_slave_port ssp_chk #(.WORD_W(WORD_W)) chk_i (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .en_i      (en_i),
   .rd_i      (rd_i),
   .wr_i      (wr_i),
   .rdata_o   (rdata_o),
   .rx_flag_o (rx_flag_o),
   .tx_flag_o (tx_flag_o),
   .data_oe_o (data_oe_o),
   .rx_ie_i   (rx_ie_i),
   .tx_ie_i   (tx_ie_i),
   .pie_i     (pie_i),
   .wake_o    (wake_o)
);

// File: tb/sync_slave_port_tb_top.sv
`timescale 1ns/1ps
module sync_slave_port_tb_top;
   logic       clk = 1'b0;
   logic       clk_run = 1'b1;
   logic       rst = 1'b1;
   logic       en = 1'b0, mode_tx = 1'b0;
   logic       sclk = 1'b0, din = 1'b0;
   logic       dout, doe;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rx_flag, tx_flag, ovr_flag;
   logic       rx_ie = 1'b0, tx_ie = 1'b0, pie = 1'b0;
   logic       wake;
   int         checks = 0;
   int         errors = 0;

   always #10 if (clk_run) clk = ~clk;

   sync_slave_port dut_i (
      .clk_i(clk), .rst_i(rst), .en_i(en), .mode_tx_i(mode_tx),
      .sclk_i(sclk), .data_i(din), .data_o(dout), .data_oe_o(doe),
      .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata),
      .rx_flag_o(rx_flag), .tx_flag_o(tx_flag), .ovr_flag_o(ovr_flag),
      .rx_ie_i(rx_ie), .tx_ie_i(tx_ie), .pie_i(pie), .wake_o(wake)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         din = b[i]; #100; sclk = 1'b1; #200; sclk = 1'b0; #100;
      end
   endtask

   task automatic pulse();
      sclk = 1'b1; #200; sclk = 1'b0; #200;
   endtask

   task automatic read_byte(output logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         v[i] = dout; pulse();
      end
   endtask

   task automatic host_write(input logic [7:0] b);
      @(negedge clk); wr = 1'b1; wdata = b;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic host_read(output logic [7:0] v);
      @(negedge clk); v = rdata; rd = 1'b1;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 rx flag after reset", rx_flag, 0);
      check("R1 tx flag after reset", tx_flag, 1);
      check("R1 ovr flag after reset", ovr_flag, 0);
      check("R1 oe after reset", doe, 0);
   endtask

   task automatic t_rx_basic();
      logic [7:0] v;
      en = 1'b1; mode_tx = 1'b0; rx_ie = 1'b1; tx_ie = 1'b0; pie = 1'b1;
      send_byte(8'hA5); hclk(4);
      check("R3 rx flag set", rx_flag, 1);
      check("R2 rx data lsb first", rdata, 8'hA5);
      check("R10 rx wake", wake, 1);
      check("R9 no drive in rx mode", doe, 0);
      host_read(v); hclk(1);
      check("R4 rx flag cleared by read", rx_flag, 0);
      check("R10 wake drops after read", wake, 0);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      send_byte(8'h3C); send_byte(8'h81); hclk(4);
      check("R5 ovr flag set", ovr_flag, 1);
      check("R5 first word kept", rdata, 8'h3C);
      host_read(v); hclk(1);
      check("R5 read returns first", v, 8'h3C);
      check("R4 ovr cleared by read", ovr_flag, 0);
      check("R4 rx cleared by read", rx_flag, 0);
      send_byte(8'h5A); hclk(4);
      check("R3 next word after overrun", rdata, 8'h5A);
      check("R5 no overrun on clean word", ovr_flag, 0);
      host_read(v);
   endtask

   task automatic t_gated();
      logic [7:0] v;
      en = 1'b0; send_byte(8'hFF); hclk(4);
      check("R2 disabled ignores clock", rx_flag, 0);
      en = 1'b1; mode_tx = 1'b1; send_byte(8'h77); hclk(4);
      check("R2 tx mode receives nothing", rx_flag, 0);
      check("R9 no drive without word", doe, 0);
      mode_tx = 1'b0; send_byte(8'h12); hclk(4);
      check("R2 word after gating", rdata, 8'h12);
      host_read(v);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      int idle;
      mode_tx = 1'b1; hclk(2);
      check("R6 tx flag free", tx_flag, 1);
      host_write(8'h96);
      check("R6 write clears tx flag", tx_flag, 0);
      hclk(5);
      check("R7 no load without sclk", doe, 0);
      idle = 0;
      while (!doe && idle < 6) begin pulse(); idle++; end
      check("R7 load on third rising edge", idle, 3);
      hclk(4);
      check("R8 holding freed on load", tx_flag, 1);
      host_write(8'h4B);
      check("R6 second write clears", tx_flag, 0);
      host_write(8'hFF);
      read_byte(v);
      check("R7 first word lsb first", v, 8'h96);
      check("R8 back to back keeps oe", doe, 1);
      hclk(4);
      check("R8 flag set on reload", tx_flag, 1);
      read_byte(v);
      check("R6 ignored write not sent", v, 8'h4B);
      check("R8 empty drops oe", doe, 0);
   endtask

   task automatic t_sleep_rx();
      logic [7:0] v;
      mode_tx = 1'b0; rx_ie = 1'b1; tx_ie = 1'b0; pie = 1'b1;
      @(negedge clk); clk_run = 1'b0; #50;
      send_byte(8'hE7); #20;
      check("R10 wake without host clock", wake, 1);
      clk_run = 1'b1; hclk(4);
      host_read(v);
      check("R3 word received in sleep", v, 8'hE7);
      hclk(1);
      check("R10 wake clears after read", wake, 0);
   endtask

   task automatic t_sleep_tx();
      logic [7:0] v;
      mode_tx = 1'b1; rx_ie = 1'b0; tx_ie = 1'b1; pie = 1'b0; #5;
      check("R10 pie gates wake", wake, 0);
      pie = 1'b1; #5;
      check("R10 tx free wakes", wake, 1);
      host_write(8'hA1); #5;
      check("R10 no wake while holding full", wake, 0);
      @(negedge clk); clk_run = 1'b0; #50;
      pulse(); pulse(); pulse(); #20;
      check("R10 tx wake in sleep", wake, 1);
      check("R9 drive when loaded", doe, 1);
      read_byte(v);
      check("R7 word sent in sleep", v, 8'hA1);
      check("R9 oe off after word", doe, 0);
      clk_run = 1'b1; hclk(2);
   endtask

   task automatic t_reset_mid();
      logic [7:0] v;
      mode_tx = 1'b0; pie = 1'b0;
      for (int i = 0; i < 4; i++) begin
         din = 1'b1; #100; sclk = 1'b1; #200; sclk = 1'b0; #100;
      end
      @(negedge clk); rst = 1'b1; hclk(3); rst = 1'b0; hclk(2);
      t_reset();
      send_byte(8'hC3); hclk(4);
      check("R1 counter cleared by reset", rdata, 8'hC3);
      check("R1 flag after realigned word", rx_flag, 1);
      host_read(v);
   endtask

   initial begin
      hclk(4); rst = 1'b0; hclk(2);
      t_reset();
      t_rx_basic();
      t_overrun();
      t_gated();
      t_tx();
      t_sleep_rx();
      t_sleep_tx();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule